// File: doc/BRIEF.md
# Floppy Controller Register and Interrupt Core

This block is the host-facing register file of a floppy disk controller. A byte-wide bus reaches sixteen registers. Each register sits on its own 16-byte slot, so address bits [7:4] pick the register and bits [3:0] are ignored. The bank holds the command byte, the interrupt flags and their enable mask, a sticky error register, a free-running down-timer, a step counter for seeks, and the plain track, sector, count and gap registers.

The command byte has no direct write path. One address clears every bit written as 1, and another address sets every bit written as 1. A host can therefore change single command bits without reading the byte first.

Events from the media logic set interrupt flags that stay set: seek finished, sector seen, transfer finished, error and data changed. A read of the flag register returns the flags and clears them. A read of the error register clears the error bits. One interrupt line leaves the block.

Top module: `fdc_regcore`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The register index is `bus_addr[7:4]` and `bus_addr[3:0]` is ignored. Indices 0 (data), 3 (mode), 4 (select), 5 (setup), 12 (gap), 13 (sector), 14 (count) and 15 (interrupt enable) read back the last value written to them.
- R3: A write to index 6 clears each command bit whose write-data bit is 1 and leaves the other bits unchanged. A read of index 6 returns the command byte. Bit 7 is the seek-run bit and bit 0 is the interrupt-output enable.
- R4: A write to index 7 sets each command bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A read of index 8 returns the flag byte and clears it. The flag bits are: 5 error, 4 data changed, 3 transfer done, 2 sector seen, 1 seek done, 0 timer done. Bits 7:6 read 0. A write to index 8 has no effect.
- R6: An event that arrives in the same cycle as a clearing read of index 8 is still pending afterwards.
- R7: Bits on `err_in` are ORed into the error register at index 2, and any nonzero `err_in` sets flag bit 5. A read of index 2 returns the error byte and clears it.
- R8: A write to index 1 loads the timer. The timer then decreases by one on every prescaler tick while it is nonzero, one tick every `TICK_DIV` clocks. The step from 1 to 0 sets flag bit 0.
- R9: A write to index 9 loads the seek counter. The counter decreases by one on each `step_pulse` only while command bit 7 is set and the count is nonzero. The step from 1 to 0 sets flag bit 1. Step pulses arriving while bit 7 is clear leave the count unchanged.
- R10: `irq_o` is high exactly when command bit 0 is set and (flags & enable) is nonzero. Status bit 1 shows (flags & enable) != 0 whatever command bit 0 holds.
- R11: A read of index 7 returns the status byte: {fifo_one, fifo_two, error register nonzero, 0, drv_sense, rd_level, pending, mark_seen}, MSB first.
- R12: When `pos_valid` is high, the current-track register (index 10) and current-sector register (index 11) take `pos_track` and `pos_sector`. Host writes to these registers also work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits [7:4] select the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| step_pulse | input | 1 | One head step taken |
| ev_sector_seen | input | 1 | Sector header passed |
| ev_xfer_done | input | 1 | Transfer finished |
| ev_data_changed | input | 1 | Drive sense data changed |
| err_in | input | 8 | Error bits to record |
| pos_valid | input | 1 | Load track and sector position |
| pos_track | input | 8 | Observed track |
| pos_sector | input | 8 | Observed sector |
| fifo_one | input | 1 | FIFO holds one byte |
| fifo_two | input | 1 | FIFO holds two bytes |
| drv_sense | input | 1 | Selected drive sense line |
| rd_level | input | 1 | Read data level |
| mark_seen | input | 1 | Mark byte in FIFO |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event that lands in the very clock cycle in which a flag-clearing read takes effect. The bench drives the read of index 8 and a sector-seen pulse on the same clock edge, and then reads again to confirm that the flag survived. The timer's zero crossing cannot be timed precisely, because the prescaler runs freely from reset. The bench therefore builds the design with a short tick divider and waits long enough to cover every possible tick phase before it checks flag bit 0. The seek counter is driven both with the seek-run bit clear and with it set, which shows that steps are ignored in the first case.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    localparam int REG_W = 8;

    typedef enum logic [3:0] {
        IX_DATA   = 4'd0,
        IX_TIMER  = 4'd1,
        IX_ERROR  = 4'd2,
        IX_MODE   = 4'd3,
        IX_SELECT = 4'd4,
        IX_SETUP  = 4'd5,
        IX_CMDCLR = 4'd6,
        IX_CMDSET = 4'd7,
        IX_FLAGS  = 4'd8,
        IX_SEEK   = 4'd9,
        IX_CTRK   = 4'd10,
        IX_CSEC   = 4'd11,
        IX_GAP    = 4'd12,
        IX_SECTOR = 4'd13,
        IX_COUNT  = 4'd14,
        IX_ENABLE = 4'd15
    } reg_ix_e;

    localparam int CMD_SEEK_RUN = 7;
    localparam int CMD_IRQ_EN   = 0;

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] error;
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] sel;
        logic [REG_W-1:0] setup;
        logic [REG_W-1:0] cmd;
        logic [REG_W-1:0] flags;
        logic [REG_W-1:0] ctrk;
        logic [REG_W-1:0] csec;
        logic [REG_W-1:0] gap;
        logic [REG_W-1:0] sector;
        logic [REG_W-1:0] count;
        logic [REG_W-1:0] enable;
    } bank_t;
endpackage

// File: rtl/fdc_prescaler.sv
module fdc_prescaler #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/fdc_dcount.sv
module fdc_dcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         hit_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt      = cnt_q;
    assign hit_zero = dec && !load && (cnt_q == ONE);
endmodule

// File: rtl/fdc_regcore.sv
module fdc_regcore
    import fdc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TICK_DIV = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              step_pulse,
    input  logic              ev_sector_seen,
    input  logic              ev_xfer_done,
    input  logic              ev_data_changed,
    input  logic [7:0]        err_in,
    input  logic              pos_valid,
    input  logic [7:0]        pos_track,
    input  logic [7:0]        pos_sector,
    input  logic              fifo_one,
    input  logic              fifo_two,
    input  logic              drv_sense,
    input  logic              rd_level,
    input  logic              mark_seen,
    output logic              irq_o
);
    localparam int IX_LSB = ADDR_W - 4;

    bank_t st_d, st_q;

    logic       wr_en, rd_en;
    reg_ix_e    ix;
    logic       tick;
    logic [7:0] tmr_cnt, seek_cnt;
    logic       tmr_zero, seek_zero;
    logic [5:0] events;
    logic       pending;
    logic       unused_addr_bits;

    assign ix               = reg_ix_e'(bus_addr[ADDR_W-1:IX_LSB]);
    assign unused_addr_bits = ^bus_addr[IX_LSB-1:0];
    assign wr_en            = bus_sel && bus_wr;
    assign rd_en            = bus_sel && !bus_wr;

    fdc_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    fdc_dcount #(.W(REG_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_en && ix == IX_TIMER),
        .load_val(bus_wdata),
        .dec     (tick),
        .cnt     (tmr_cnt),
        .hit_zero(tmr_zero)
    );

    fdc_dcount #(.W(REG_W)) u_seek (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_en && ix == IX_SEEK),
        .load_val(bus_wdata),
        .dec     (step_pulse && st_q.cmd[CMD_SEEK_RUN]),
        .cnt     (seek_cnt),
        .hit_zero(seek_zero)
    );

    assign events  = {(err_in != 8'h00), ev_data_changed, ev_xfer_done,
                      ev_sector_seen, seek_zero, tmr_zero};
    assign pending = |(st_q.flags & st_q.enable);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (ix)
                IX_DATA:   st_d.data   = bus_wdata;
                IX_MODE:   st_d.mode   = bus_wdata;
                IX_SELECT: st_d.sel    = bus_wdata;
                IX_SETUP:  st_d.setup  = bus_wdata;
                IX_CMDCLR: st_d.cmd    = st_q.cmd & ~bus_wdata;
                IX_CMDSET: st_d.cmd    = st_q.cmd | bus_wdata;
                IX_CTRK:   st_d.ctrk   = bus_wdata;
                IX_CSEC:   st_d.csec   = bus_wdata;
                IX_GAP:    st_d.gap    = bus_wdata;
                IX_SECTOR: st_d.sector = bus_wdata;
                IX_COUNT:  st_d.count  = bus_wdata;
                IX_ENABLE: st_d.enable = bus_wdata;
                default:   ;
            endcase
        end
        if (pos_valid) begin
            st_d.ctrk = pos_track;
            st_d.csec = pos_sector;
        end
        st_d.error = ((rd_en && ix == IX_ERROR) ? 8'h00 : st_q.error) | err_in;
        st_d.flags = ((rd_en && ix == IX_FLAGS) ? 8'h00 : st_q.flags) | {2'b00, events};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (ix)
            IX_DATA:   bus_rdata = st_q.data;
            IX_TIMER:  bus_rdata = tmr_cnt;
            IX_ERROR:  bus_rdata = st_q.error;
            IX_MODE:   bus_rdata = st_q.mode;
            IX_SELECT: bus_rdata = st_q.sel;
            IX_SETUP:  bus_rdata = st_q.setup;
            IX_CMDCLR: bus_rdata = st_q.cmd;
            IX_CMDSET: bus_rdata = {fifo_one, fifo_two, (st_q.error != 8'h00), 1'b0,
                                    drv_sense, rd_level, pending, mark_seen};
            IX_FLAGS:  bus_rdata = st_q.flags;
            IX_SEEK:   bus_rdata = seek_cnt;
            IX_CTRK:   bus_rdata = st_q.ctrk;
            IX_CSEC:   bus_rdata = st_q.csec;
            IX_GAP:    bus_rdata = st_q.gap;
            IX_SECTOR: bus_rdata = st_q.sector;
            IX_COUNT:  bus_rdata = st_q.count;
            default:   bus_rdata = st_q.enable;
        endcase
    end

    assign irq_o = st_q.cmd[CMD_IRQ_EN] && pending;
endmodule

// File: rtl/fdc_regcore_props.sv
module fdc_regcore_props #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              ev_sector_seen,
    input logic [7:0]        err_in,
    input logic [7:0]        cmd,
    input logic [7:0]        flags,
    input logic [7:0]        error,
    input logic [7:0]        tmr_cnt,
    input logic              irq_o
);
    logic [3:0] ix;
    assign ix = bus_addr[ADDR_W-1 -: 4];

    assert_cmd_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && ix == 4'd7) |=> ((cmd & $past(bus_wdata)) == $past(bus_wdata)));

    assert_cmd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && ix == 4'd6) |=> ((cmd & $past(bus_wdata)) == 8'h00));

    assert_event_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sector_seen |=> flags[2]);

    assert_error_records_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_in != 8'h00) |=> (flags[5] && ((error & $past(err_in)) == $past(err_in))));

    assert_timer_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cnt == 8'h00 && $past(tmr_cnt) == 8'h01
         && !$past(bus_sel && bus_wr && ix == 4'd1)) |-> flags[0]);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd[0] |-> !irq_o);
endmodule

bind fdc_regcore fdc_regcore_props #(.ADDR_W(ADDR_W)) u_props (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .ev_sector_seen(ev_sector_seen),
    .err_in        (err_in),
    .cmd           (st_q.cmd),
    .flags         (st_q.flags),
    .error         (st_q.error),
    .tmr_cnt       (tmr_cnt),
    .irq_o         (irq_o)
);

// File: tb/fdc_regcore_test.sv
module fdc_regcore_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       step_pulse = 1'b0, ev_sector_seen = 1'b0, ev_xfer_done = 1'b0, ev_data_changed = 1'b0;
    logic [7:0] err_in = 8'h00;
    logic       pos_valid = 1'b0;
    logic [7:0] pos_track = 8'h00, pos_sector = 8'h00;
    logic       fifo_one = 1'b0, fifo_two = 1'b0, drv_sense = 1'b0, rd_level = 1'b0, mark_seen = 1'b0;
    logic       irq_o;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fdc_regcore #(.ADDR_W(8), .TICK_DIV(4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .step_pulse(step_pulse), .ev_sector_seen(ev_sector_seen),
        .ev_xfer_done(ev_xfer_done), .ev_data_changed(ev_data_changed),
        .err_in(err_in), .pos_valid(pos_valid), .pos_track(pos_track),
        .pos_sector(pos_sector), .fifo_one(fifo_one), .fifo_two(fifo_two),
        .drv_sense(drv_sense), .rd_level(rd_level), .mark_seen(mark_seen),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        rd(8'h80, d);
        rd(8'h20, d);
        rd(8'h80, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h60, d); chk("R1 cmd", d, 8'h00);
        rd(8'h80, d); chk("R1 flags", d, 8'h00);
        rd(8'h00, d); chk("R1 data", d, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_regfile();
        logic [7:0] d;
        logic [3:0] ixs [8] = '{4'd0, 4'd3, 4'd4, 4'd5, 4'd12, 4'd13, 4'd14, 4'd15};
        foreach (ixs[i]) wr({ixs[i], 4'h5}, 8'h11 * (i + 1) ^ 8'h40);
        foreach (ixs[i]) begin
            rd({ixs[i], 4'hA}, d);
            chk("R2 readback", d, 8'h11 * (i + 1) ^ 8'h40);
        end
        wr(8'hF0, 8'h00);
    endtask

    task automatic t_cmd();
        logic [7:0] d;
        wr(8'h70, 8'hA4);  rd(8'h60, d); chk("R4 set", d, 8'hA4);
        wr(8'h70, 8'h01);  rd(8'h60, d); chk("R4 set keeps", d, 8'hA5);
        wr(8'h60, 8'h81);  rd(8'h60, d); chk("R3 clear", d, 8'h24);
        wr(8'h60, 8'hFF);  rd(8'h60, d); chk("R3 clear all", d, 8'h00);
    endtask

    task automatic t_flags();
        logic [7:0] d;
        clear_all();
        @(negedge clk); ev_xfer_done = 1'b1; ev_data_changed = 1'b1;
        @(negedge clk); ev_xfer_done = 1'b0; ev_data_changed = 1'b0;
        wr(8'h80, 8'hFF);
        rd(8'h80, d); chk("R5 flags", d, 8'h18);
        rd(8'h80, d); chk("R5 cleared", d, 8'h00);
        // R6: event on the same edge as the clearing read
        @(negedge clk); ev_sector_seen = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h80;
        @(posedge clk); #1; bus_sel = 1'b0; ev_sector_seen = 1'b0;
        rd(8'h80, d); chk("R6 kept", d, 8'h04);
    endtask

    task automatic t_error();
        logic [7:0] d;
        clear_all();
        @(negedge clk); err_in = 8'h80;
        @(negedge clk); err_in = 8'h01;
        @(negedge clk); err_in = 8'h00;
        rd(8'h20, d); chk("R7 error bits", d, 8'h81);
        rd(8'h20, d); chk("R7 error cleared", d, 8'h00);
        rd(8'h80, d); chk("R7 error flag", d, 8'h20);
    endtask

    task automatic t_timer();
        logic [7:0] d;
        clear_all();
        wr(8'h10, 8'h03);
        rd(8'h80, d); chk("R8 not early", d & 8'h01, 8'h00);
        repeat (20) @(posedge clk);
        rd(8'h10, d); chk("R8 timer zero", d, 8'h00);
        rd(8'h80, d); chk("R8 timer flag", d, 8'h01);
        repeat (12) @(posedge clk);
        rd(8'h80, d); chk("R8 no refire", d, 8'h00);
    endtask

    task automatic pulse_step();
        @(negedge clk); step_pulse = 1'b1;
        @(negedge clk); step_pulse = 1'b0;
    endtask

    task automatic t_seek();
        logic [7:0] d;
        clear_all();
        wr(8'h90, 8'h02);
        pulse_step();
        rd(8'h90, d); chk("R9 ignored without run", d, 8'h02);
        wr(8'h70, 8'h80);
        pulse_step();
        rd(8'h90, d); chk("R9 one step", d, 8'h01);
        rd(8'h80, d); chk("R9 no flag yet", d, 8'h00);
        pulse_step();
        rd(8'h90, d); chk("R9 reached zero", d, 8'h00);
        rd(8'h80, d); chk("R9 seek flag", d, 8'h02);
        pulse_step();
        rd(8'h90, d); chk("R9 stays zero", d, 8'h00);
        wr(8'h60, 8'h80);
    endtask

    task automatic t_status();
        logic [7:0] d;
        clear_all();
        fifo_one = 1'b1; drv_sense = 1'b1; mark_seen = 1'b1;
        rd(8'h70, d); chk("R11 status", d, 8'h89);
        fifo_one = 1'b0; fifo_two = 1'b1; rd_level = 1'b1; drv_sense = 1'b0; mark_seen = 1'b0;
        @(negedge clk); err_in = 8'h04;
        @(negedge clk); err_in = 8'h00;
        rd(8'h70, d); chk("R11 status err", d, 8'h64);
        fifo_two = 1'b0; rd_level = 1'b0;
        clear_all();
    endtask

    task automatic t_irq();
        logic [7:0] d;
        clear_all();
        wr(8'hF0, 8'h04);
        wr(8'h70, 8'h01);
        @(negedge clk); ev_xfer_done = 1'b1;
        @(negedge clk); ev_xfer_done = 1'b0;
        chk("R10 masked event", {7'd0, irq_o}, 8'h00);
        @(negedge clk); ev_sector_seen = 1'b1;
        @(negedge clk); ev_sector_seen = 1'b0;
        chk("R10 irq high", {7'd0, irq_o}, 8'h01);
        rd(8'h70, d); chk("R10 pending bit", d & 8'h02, 8'h02);
        rd(8'h80, d);
        @(negedge clk);
        chk("R10 irq cleared", {7'd0, irq_o}, 8'h00);
        wr(8'h60, 8'h01);
        @(negedge clk); ev_sector_seen = 1'b1;
        @(negedge clk); ev_sector_seen = 1'b0;
        chk("R10 irq gated", {7'd0, irq_o}, 8'h00);
        rd(8'h70, d); chk("R10 pending ungated", d & 8'h02, 8'h02);
        wr(8'hF0, 8'h00);
        clear_all();
    endtask

    task automatic t_position();
        logic [7:0] d;
        wr(8'hA0, 8'h10);
        rd(8'hA0, d); chk("R12 host track", d, 8'h10);
        @(negedge clk); pos_valid = 1'b1; pos_track = 8'h21; pos_sector = 8'h07;
        @(negedge clk); pos_valid = 1'b0;
        rd(8'hA0, d); chk("R12 track", d, 8'h21);
        rd(8'hB0, d); chk("R12 sector", d, 8'h07);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                t_reset();
                t_regfile();
                t_cmd();
                t_flags();
                t_error();
                t_timer();
                t_seek();
                t_status();
                t_irq();
                t_position();
            end
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule